// File: doc/BRIEF.md
# Zero-turnaround synchronous SRAM

This block is a synthesizable model of a single-port synchronous static memory. Its bus can switch between reads and writes on consecutive clocks with no idle cycle. Address, command and byte enables are registered on each rising clock edge that has the clock enable high. Write data is not taken with the command. It arrives a fixed number of enabled edges later, in the same slot where a read would return its data. Because of this, a write placed right after a read needs no dead cycle on the shared data bus.

A static mode pin sets the latency. In pipelined operation, read data passes through an output register and appears one clock after the access cycle, and write data follows the command by two enabled edges. In flow-through operation, read data appears within the access cycle, and write data follows by one enabled edge. A read placed between a write command and that write's data still returns the newest contents. The pending bytes are merged with the array bytes that the write leaves alone. The data bus is modelled as separate input, output and drive-enable signals. An asynchronous output enable can cut the drivers at any moment.

Top module: `nt_sram`

## Requirements
- R1: With `flow_n` = 1 (pipelined), a selected read issued on enabled edge n drives `dq_oe` = 1 and the word on `dq_out` from just after edge n+1 until the next enabled edge.
- R2: With `flow_n` = 0 (flow-through), a selected read issued on enabled edge n drives `dq_oe` = 1 and the word on `dq_out` from just after edge n until the next enabled edge.
- R3: Write data on `dq_in` is taken on the second enabled edge after the write command in pipelined operation, and on the first enabled edge after it in flow-through operation.
- R4: `bw_n[k]` = 0 on the write command writes bits [9k+8:9k] of the word. Bytes whose enable is 1 keep their old contents. All enables at 1 leaves the word unchanged.
- R5: The device is selected only when `ce0_n` = 0, `ce1` = 1 and `ce2_n` = 0. An unselected command performs no access. Its read slot leaves `dq_oe` = 0, and a write attempted while unselected leaves memory unchanged.
- R6: `oe_n` = 1 forces `dq_oe` = 0 immediately, without waiting for a clock. Clearing `oe_n` restores the drive state that the clocked logic holds.
- R7: An edge with `cke` = 0 changes no state. No command is taken and no write data is sampled. A driven read word stays on the bus, and pending latencies are counted in enabled edges only.
- R8: Reads and writes may alternate on every cycle with no idle cycle. A read of an address whose write data is still due returns that write merged with the array bytes it does not cover.
- R9: `flow_n` is static while out of reset. 0 selects flow-through operation and 1 selects pipelined operation.
- R10: While `rst_n` = 0 and just after its release, `dq_oe` = 0 and no read or write is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the command pipeline |
| flow_n | input | 1 | Static mode: 0 flow-through, 1 pipelined |
| cke | input | 1 | Clock enable; 0 holds all state |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Command: 0 write, 1 read |
| bw_n | input | NBYTES | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | NBYTES*BYTE_W | Data bus, inbound half |
| dq_out | output | NBYTES*BYTE_W | Data bus, outbound half |
| dq_oe | output | 1 | Data bus drive enable |
| oe_n | input | 1 | Asynchronous output enable, active low |

## Verification
The bench uses the default parameters: 256 words of four 9-bit bytes. This lets it fill every address before any read, so each compared word is known to its reference memory. It runs the same command sequence once with `flow_n` high and once with it low, switching between the runs under reset. One build therefore covers both write lags, and the read that falls between a pipelined write command and its data. The drive enable is compared on every cycle, so each deselect, hold and output-enable pattern is checked with its exact latency.

// File: rtl/nts_pkg.sv
package nts_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } nts_op_e;

  // All three enables must agree for the device to take a command
  function automatic logic chip_selected(input logic e0_n, input logic e1, input logic e2_n);
    return !e0_n && e1 && !e2_n;
  endfunction

  function automatic nts_op_e decode_op(input logic sel, input logic we_n);
    if (!sel) return OP_IDLE;
    return we_n ? OP_READ : OP_WRITE;
  endfunction

endpackage

// File: rtl/nts_ctrl.sv
module nts_ctrl
  import nts_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              flow,
  input  logic              cmd_sel,
  input  logic              we_n,
  input  logic [NBYTES-1:0] bw_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [NBYTES-1:0] wr_bw_n,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              drive_sync
);

  nts_op_e           s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [NBYTES-1:0] s1_bw, s2_bw;

  // Two command stages, both frozen while cke is low
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s2_op   <= OP_IDLE;
      s1_addr <= '0;
      s2_addr <= '0;
      s1_bw   <= '1;
      s2_bw   <= '1;
    end else if (cke) begin
      s1_op   <= decode_op(cmd_sel, we_n);
      s1_addr <= addr;
      s1_bw   <= bw_n;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_bw   <= s1_bw;
    end
  end

  // Flow-through writes retire from stage 1, pipelined writes from stage 2
  assign wr_commit  = cke && (flow ? (s1_op == OP_WRITE) : (s2_op == OP_WRITE));
  assign wr_addr    = flow ? s1_addr : s2_addr;
  assign wr_bw_n    = flow ? s1_bw : s2_bw;
  assign rd_addr    = s1_addr;
  assign drive_sync = flow ? (s1_op == OP_READ) : (s2_op == OP_READ);

endmodule

// File: rtl/nts_array.sv
module nts_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NBYTES = 4,
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned DATA_W = NBYTES * BYTE_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_commit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NBYTES-1:0] wr_bw_n,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] wr_word
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] wr_mask;

  for (genvar b = 0; b < NBYTES; b++) begin : g_mask
    assign wr_mask[b*BYTE_W +: BYTE_W] = {BYTE_W{!wr_bw_n[b]}};
  end

  // Merged word: new bytes where enabled, stored bytes elsewhere
  assign wr_word = (mem[wr_addr] & ~wr_mask) | (din & wr_mask);

  always_ff @(posedge clk) begin
    if (wr_commit) mem[wr_addr] <= wr_word;
  end

  // A read of the word being written this edge sees the merged result
  assign rd_word = (wr_commit && (wr_addr == rd_addr)) ? wr_word : mem[rd_addr];

endmodule

// File: rtl/nts_outpath.sv
module nts_outpath #(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              flow,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              drive_sync,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   out_q <= '0;
    else if (cke) out_q <= rd_word;
  end

  assign dq_out = flow ? rd_word : out_q;
  assign dq_oe  = drive_sync && !oe_n;

endmodule

// File: rtl/nt_sram.sv
module nt_sram
  import nts_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NBYTES = 4,
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flow_n,
  input  logic              cke,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              ce2_n,
  input  logic              we_n,
  input  logic [NBYTES-1:0] bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic              oe_n
);

  logic              flow;
  logic              cmd_sel;
  logic              cmd_rd;
  logic              cmd_wr;
  logic              wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [NBYTES-1:0] wr_bw_n;
  logic [ADDR_W-1:0] rd_addr;
  logic              drive_sync;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] wr_word;

  assign flow    = !flow_n;
  assign cmd_sel = chip_selected(ce0_n, ce1, ce2_n);
  assign cmd_rd  = cmd_sel && we_n;
  assign cmd_wr  = cmd_sel && !we_n;

  nts_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .flow       (flow),
    .cmd_sel    (cmd_sel),
    .we_n       (we_n),
    .bw_n       (bw_n),
    .addr       (addr),
    .wr_commit  (wr_commit),
    .wr_addr    (wr_addr),
    .wr_bw_n    (wr_bw_n),
    .rd_addr    (rd_addr),
    .drive_sync (drive_sync)
  );

  nts_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk       (clk),
    .wr_commit (wr_commit),
    .wr_addr   (wr_addr),
    .wr_bw_n   (wr_bw_n),
    .din       (dq_in),
    .rd_addr   (rd_addr),
    .rd_word   (rd_word),
    .wr_word   (wr_word)
  );

  nts_outpath #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .flow       (flow),
    .rd_word    (rd_word),
    .drive_sync (drive_sync),
    .oe_n       (oe_n),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe)
  );

endmodule

// File: rtl/nts_sva.sv
module nts_sva #(
  parameter int unsigned DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flow,
  input logic              cke,
  input logic              cmd_sel,
  input logic              cmd_rd,
  input logic              cmd_wr,
  input logic              wr_commit,
  input logic              drive_sync,
  input logic              oe_n,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out
);

  // R1: a pipelined read followed by an enabled edge is on the bus
  a_r1_pipe_read_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow && cke && cmd_rd) ##1 cke |=> drive_sync);

  // R2: a flow-through read is on the bus after its own edge
  a_r2_flow_read_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (flow && cke && cmd_rd) |=> drive_sync);

  // R3: flow-through write retires on the next enabled edge
  a_r3_flow_write_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (flow && cke && cmd_wr) |=> (wr_commit || !cke));

  // R3: pipelined write retires on the second enabled edge
  a_r3_pipe_write_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow && cke && cmd_wr) ##1 cke |=> (wr_commit || !cke));

  // R5: deselect releases the bus after the mode latency
  a_r5_flow_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (flow && cke && !cmd_sel) |=> !drive_sync);

  a_r5_pipe_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow && cke && !cmd_sel) ##1 cke |=> !drive_sync);

  // R6: output enable overrides the clocked drive
  a_r6_oe_override: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  // R7: a held edge keeps the drive state and a driven word
  a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(drive_sync) && (!drive_sync || $stable(dq_out))));

endmodule

bind nt_sram nts_sva #(.DATA_W(DATA_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .flow       (flow),
  .cke        (cke),
  .cmd_sel    (cmd_sel),
  .cmd_rd     (cmd_rd),
  .cmd_wr     (cmd_wr),
  .wr_commit  (wr_commit),
  .drive_sync (drive_sync),
  .oe_n       (oe_n),
  .dq_oe      (dq_oe),
  .dq_out     (dq_out)
);

// File: tb/nt_sram_tb_top.sv
module nt_sram_tb_top;

  logic        clk;
  logic        rst_n;
  logic        flow_n;
  logic        cke;
  logic        ce0_n, ce1, ce2_n;
  logic        we_n;
  logic [3:0]  bw_n;
  logic [7:0]  addr;
  logic [35:0] dq_in;
  logic [35:0] dq_out;
  logic        dq_oe;
  logic        oe_n;

  int n_tests = 0;
  int n_fail  = 0;

  nt_sram dut_i (
    .clk(clk), .rst_n(rst_n), .flow_n(flow_n), .cke(cke),
    .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .we_n(we_n),
    .bw_n(bw_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .oe_n(oe_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [7:0]  a;
    logic [3:0]  bw;
    logic [35:0] d;
    int          rem;
  } wr_t;

  typedef struct packed {
    logic        oe;
    logic [35:0] d;
  } exp_t;

  wr_t         wq[$];
  exp_t        eq[$];
  string       tq[$];
  logic [35:0] ref_mem [256];
  logic        m1_v = 1'b0, m2_v = 1'b0;
  logic [7:0]  m1_a = 8'h0;
  logic [35:0] m2_d = '0;

  function automatic logic [35:0] byte_merge(input logic [35:0] old, input logic [35:0] nw,
                                             input logic [3:0] en_n);
    logic [35:0] r;
    r = old;
    for (int k = 0; k < 4; k++)
      if (!en_n[k]) r[k*9 +: 9] = nw[k*9 +: 9];
    return r;
  endfunction

  // Driver: updates the reference at each edge, drives the next cycle, queues the expectation
  task automatic step(input string tag, input logic c_cke, input logic [2:0] cs, input logic c_we,
                      input logic [3:0] c_bw, input logic [7:0] c_a, input logic c_oe);
    logic        sel;
    logic        drv;
    logic [35:0] nd;
    exp_t        e;
    @(posedge clk);
    if (!rst_n) begin
      m1_v = 1'b0;
      m2_v = 1'b0;
      wq.delete();
    end else if (cke) begin
      foreach (wq[i]) wq[i].rem = wq[i].rem - 1;
      if (wq.size() > 0 && wq[0].rem == 0) begin
        ref_mem[wq[0].a] = byte_merge(ref_mem[wq[0].a], wq[0].d, wq[0].bw);
        void'(wq.pop_front());
      end
      sel = (ce0_n == 1'b0) && (ce1 == 1'b1) && (ce2_n == 1'b0);
      if (flow_n) begin
        m2_v = m1_v;
        m2_d = ref_mem[m1_a];
      end
      m1_v = sel && we_n;
      m1_a = addr;
      if (sel && !we_n) begin
        nd = {4'($urandom()), 32'($urandom())};
        wq.push_back('{a: addr, bw: bw_n, d: nd, rem: (flow_n ? 2 : 1)});
      end
    end
    #5;
    cke = c_cke;
    {ce0_n, ce1, ce2_n} = cs;
    we_n = c_we;
    bw_n = c_bw;
    addr = c_a;
    oe_n = c_oe;
    if (wq.size() > 0 && wq[0].rem == 1) dq_in = wq[0].d;
    else dq_in = {4'($urandom()), 32'($urandom())};
    drv  = flow_n ? m2_v : m1_v;
    e.oe = drv && !c_oe;
    e.d  = flow_n ? m2_d : ref_mem[m1_a];
    eq.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [3:0] bw);
    step(tag, 1'b1, 3'b010, 1'b0, bw, a, 1'b0);
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic o = 1'b0);
    step(tag, 1'b1, 3'b010, 1'b1, 4'hf, a, o);
  endtask

  task automatic idle(input string tag, input logic o = 1'b0);
    step(tag, 1'b1, 3'b101, 1'b1, 4'hf, 8'h0, o);
  endtask

  task automatic hold(input string tag);
    step(tag, 1'b0, 3'b010, 1'b0, 4'h0, 8'hff, 1'b0);
  endtask

  // Monitor: pops one expectation per cycle and compares at mid-low phase
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(posedge clk);
      #15;
      if (eq.size() > 0) begin
        e = eq.pop_front();
        t = tq.pop_front();
        n_tests++;
        if (dq_oe !== e.oe) begin
          n_fail++;
          $display("FAIL %s: dq_oe=%0b expected %0b", t, dq_oe, e.oe);
        end else if (e.oe) begin
          n_tests++;
          if (dq_out !== e.d) begin
            n_fail++;
            $display("FAIL %s: dq_out=%h expected %h", t, dq_out, e.d);
          end
        end
      end
    end
  end

  task automatic run_seq(input logic flow);
    string rtag;
    rtag = flow ? "R2" : "R1";
    // fill every word; R3 write lag and full-word writes
    for (int a = 0; a < 256; a++) wr("R3", 8'(a), 4'h0);
    idle("R3"); idle("R3"); idle("R3");
    rd("R9", 8'd3); idle("R9");
    for (int a = 0; a < 16; a++) rd(rtag, 8'(a));
    idle(rtag); idle(rtag); idle(rtag);
    // R8 alternating traffic, reads landing on pending writes
    wr("R8", 8'd30, 4'h0); rd("R8", 8'd30); rd("R8", 8'd30);
    wr("R8", 8'd31, 4'h0); rd("R8", 8'd31); wr("R8", 8'd30, 4'b1010);
    rd("R8", 8'd30); rd("R8", 8'd31); wr("R8", 8'd31, 4'b0110); wr("R8", 8'd30, 4'b1001);
    rd("R8", 8'd31); rd("R8", 8'd30);
    idle("R8"); idle("R8"); idle("R8");
    // R4 byte enables
    wr("R4", 8'd40, 4'b1110); rd("R4", 8'd40); wr("R4", 8'd40, 4'b0111); rd("R4", 8'd40);
    wr("R4", 8'd40, 4'hf); rd("R4", 8'd40); wr("R4", 8'd40, 4'b0101); idle("R4"); idle("R4");
    rd("R4", 8'd40); idle("R4"); idle("R4");
    // R5 each chip enable alone deselects
    step("R5", 1'b1, 3'b110, 1'b0, 4'h0, 8'd50, 1'b0);
    step("R5", 1'b1, 3'b000, 1'b1, 4'hf, 8'd50, 1'b0);
    step("R5", 1'b1, 3'b011, 1'b0, 4'h0, 8'd50, 1'b0);
    rd("R5", 8'd51);
    step("R5", 1'b1, 3'b011, 1'b1, 4'hf, 8'd51, 1'b0);
    rd("R5", 8'd50); idle("R5"); idle("R5"); idle("R5");
    rd("R5", 8'd50); idle("R5"); idle("R5");
    // R7 holds inside write and read latencies
    wr("R7", 8'd60, 4'h0); hold("R7"); hold("R7"); rd("R7", 8'd60); hold("R7");
    rd("R7", 8'd61); hold("R7"); hold("R7"); wr("R7", 8'd61, 4'b0011); hold("R7");
    rd("R7", 8'd61); hold("R7"); idle("R7"); idle("R7"); idle("R7");
    // R6 asynchronous output enable
    rd("R6", 8'd70); rd("R6", 8'd71, 1'b1); rd("R6", 8'd72, 1'b0); idle("R6", 1'b1);
    idle("R6", 1'b0); idle("R6", 1'b1); idle("R6");
  endtask

  initial begin
    rst_n = 1'b0; flow_n = 1'b1; cke = 1'b1;
    {ce0_n, ce1, ce2_n} = 3'b101;
    we_n = 1'b1; bw_n = 4'hf; addr = 8'h0; dq_in = '0; oe_n = 1'b0;
    // R10 reset behaviour
    idle("R10"); idle("R10"); idle("R10");
    rst_n = 1'b1;
    idle("R10"); idle("R10");
    run_seq(1'b0);
    idle("R10"); idle("R10");
    rst_n = 1'b0; flow_n = 1'b0;
    idle("R10"); idle("R10");
    rst_n = 1'b1;
    idle("R10");
    run_seq(1'b1);
    idle("R10"); idle("R10");
    @(posedge clk);
    #16;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule